// File: doc/BRIEF.md
# State Transition Legality Monitor

This block watches the state of a small controller every clock cycle and reports broken state behaviour on error lines. It has two modes, chosen by the `onehotMode` input. In encoded mode the low two bits of the observed vector carry one of three states: idle, run and done. The monitor flags any encoding that is not one of these states. It also judges each step from one sample to the next, and it keeps a separate error line for each source state, so a violation names the state the controller left from. In onehot mode the whole vector is checked for corruption. Exactly one bit must be set, so an all-zero vector is an error in the same way as a vector with several bits set.

The monitor is placed beside the controller it observes. A `stateValid` qualifier marks the cycles that carry a meaningful state. Each error line has two forms: a pulse that is high for one cycle for each violating sample, and a sticky copy that only reset clears.

Top module: `fsm_walk_monitor`

## Requirements
- R1: In encoded mode the state is `stateIn[1:0]`, with idle=2'b00, run=2'b01 and done=2'b10. The upper bits are ignored. A valid sample of 2'b11 sets error bit 0 (invalid encoding).
- R2: When the previous judged sample was idle, a next state of idle or run is legal. Any other next state sets error bit 1. The idle self-loop never flags.
- R3: When the previous judged sample was run, a next state of run or done is legal. Any other next state sets error bit 2. The run self-loop never flags.
- R4: When the previous judged sample was done, only idle is legal next. Anything else sets error bit 3. A previous sample of 2'b11 raises no source-state flag.
- R5: A transition is judged only between two valid samples on consecutive clock edges. A cycle with `stateValid` low checks nothing. It also makes the next valid sample a fresh start, as does the first valid sample after reset.
- R6: In onehot mode a valid sample whose population count is not exactly one sets error bit 4, and this includes zero. Error bits 0 to 3 stay low in this mode.
- R7: `errPulse` is registered. It shows the result of the sample taken at a clock edge during the cycle after that edge, for exactly one cycle. Each pulse bit also sets the matching `errSticky` bit, which then holds until reset.
- R8: While `rstN` is low all outputs are zero and no check runs, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| onehotMode | input | 1 | 1 selects the onehot corruption check, 0 selects the encoded three-state checks |
| stateValid | input | 1 | The observed state is meaningful in this cycle |
| stateIn | input | STATE_W (5) | Observed state vector |
| errPulse | output | 5 | Per-sample error flags: bit 0 invalid encoding, bit 1 left idle, bit 2 left run, bit 3 left done, bit 4 onehot corruption |
| errSticky | output | 5 | Accumulated error flags, cleared only by reset |

## Verification
The bench drives the waiting self-loops of idle and run. A monitor that left these out of the legal sets would flag every stall. It drives each illegal jump out of all three source states, so a mixed-up source attribution shows up as the wrong bit. It samples an illegal jump across a gap in `stateValid` and straight after reset, where a monitor that kept a stale previous state would raise a false flag. In onehot mode it applies the all-zero vector and multi-bit vectors, which an at-most-one check would let through. A mid-run reset shows whether the sticky bits really clear and stay clear while bad inputs are applied.

// File: rtl/fwm_pkg.sv
package fwm_pkg;
  localparam int ENC_W = 2;
  localparam int ERR_W = 5;

  localparam int ERR_BAD_ENC   = 0;
  localparam int ERR_FROM_IDLE = 1;
  localparam int ERR_FROM_RUN  = 2;
  localparam int ERR_FROM_DONE = 3;
  localparam int ERR_ONEHOT    = 4;

  typedef enum logic [ENC_W-1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10,
    ST_BAD  = 2'b11
  } encState_e;

  // strobes from control to the rule datapath
  typedef struct packed {
    logic doCheck;   // this sample is judged on its own
    logic doTrans;   // this sample is judged against the previous one
    logic capture;   // store this sample as the previous state
  } strobe_t;
endpackage

// File: rtl/fwm_ctrl.sv
module fwm_ctrl
  import fwm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    onehotMode,
  input  logic    stateValid,
  output strobe_t strb
);
  logic prevValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevValid <= 1'b0;
    else       prevValid <= stateValid;
  end

  always_comb begin
    strb.doCheck = stateValid;
    strb.capture = stateValid;
    strb.doTrans = stateValid && prevValid && !onehotMode;
  end

  // R5
  no_trans_after_gap_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    !stateValid |=> !strb.doTrans);
endmodule

// File: rtl/fwm_rules.sv
module fwm_rules
  import fwm_pkg::*;
#(
  parameter int STATE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               onehotMode,
  input  logic [STATE_W-1:0] stateIn,
  output logic [ERR_W-1:0]   hit
);
  localparam int CNT_W = $clog2(STATE_W + 1);

  encState_e curEnc;
  encState_e prevEnc;
  logic [CNT_W-1:0] setCount;

  assign curEnc = encState_e'(stateIn[ENC_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             prevEnc <= ST_IDLE;
    else if (strb.capture) prevEnc <= curEnc;
  end

  always_comb begin
    setCount = '0;
    for (int b = 0; b < STATE_W; b++) begin
      setCount = setCount + CNT_W'(stateIn[b]);
    end
  end

  always_comb begin
    hit = '0;
    if (strb.doCheck && onehotMode) begin
      hit[ERR_ONEHOT] = (setCount != CNT_W'(1));
    end
    if (strb.doCheck && !onehotMode) begin
      hit[ERR_BAD_ENC] = (curEnc == ST_BAD);
    end
    if (strb.doTrans) begin
      unique case (prevEnc)
        ST_IDLE: hit[ERR_FROM_IDLE] = !(curEnc inside {ST_IDLE, ST_RUN});
        ST_RUN:  hit[ERR_FROM_RUN]  = !(curEnc inside {ST_RUN, ST_DONE});
        ST_DONE: hit[ERR_FROM_DONE] = (curEnc != ST_IDLE);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fwm_flags.sv
module fwm_flags
  import fwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [ERR_W-1:0] hit,
  output logic [ERR_W-1:0] pulseQ,
  output logic [ERR_W-1:0] stickyQ
);
  for (genvar i = 0; i < ERR_W; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pulseQ[i]  <= 1'b0;
        stickyQ[i] <= 1'b0;
      end else begin
        pulseQ[i]  <= hit[i];
        stickyQ[i] <= stickyQ[i] | hit[i];
      end
    end

    // R7
    sticky_hold_chk: assert property (
      @(posedge clk) disable iff (!rstN)
      stickyQ[i] |=> stickyQ[i]);

    // R7
    pulse_in_sticky_chk: assert property (
      @(posedge clk) disable iff (!rstN)
      pulseQ[i] |-> stickyQ[i]);
  end
endmodule

// File: rtl/fsm_walk_monitor.sv
module fsm_walk_monitor
  import fwm_pkg::*;
#(
  parameter int STATE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               onehotMode,
  input  logic               stateValid,
  input  logic [STATE_W-1:0] stateIn,
  output logic [ERR_W-1:0]   errPulse,
  output logic [ERR_W-1:0]   errSticky
);
  strobe_t strb;
  logic [ERR_W-1:0] hit;

  fwm_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .onehotMode (onehotMode),
    .stateValid (stateValid),
    .strb       (strb)
  );

  fwm_rules #(.STATE_W(STATE_W)) uRules (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .onehotMode (onehotMode),
    .stateIn    (stateIn),
    .hit        (hit)
  );

  fwm_flags uFlags (
    .clk     (clk),
    .rstN    (rstN),
    .hit     (hit),
    .pulseQ  (errPulse),
    .stickyQ (errSticky)
  );

  // R2
  idle_wait_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    (!onehotMode && stateValid && $past(stateValid) &&
     $past(stateIn[ENC_W-1:0]) == ST_IDLE &&
     stateIn[ENC_W-1:0] inside {ST_IDLE, ST_RUN})
    |=> !errPulse[ERR_FROM_IDLE]);

  // R3
  run_wait_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    (!onehotMode && stateValid && $past(stateValid) &&
     $past(stateIn[ENC_W-1:0]) == ST_RUN &&
     stateIn[ENC_W-1:0] inside {ST_RUN, ST_DONE})
    |=> !errPulse[ERR_FROM_RUN]);

  // R5
  gap_quiet_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    !stateValid |=> (errPulse == '0));

  // R6
  onehot_catch_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    (onehotMode && stateValid && $countones(stateIn) != 1)
    |=> errPulse[ERR_ONEHOT]);

  // R6
  onehot_quiet_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    onehotMode |=> (errPulse[ERR_FROM_DONE:ERR_BAD_ENC] == '0));
endmodule

// File: tb/tb_fsm_walk_monitor.sv
module tb_fsm_walk_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 5;
  localparam int EW = 5;

  typedef struct {
    logic [EW-1:0] pulse;
    logic [EW-1:0] sticky;
    string         tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onehotMode = 1'b0;
  logic stateValid = 1'b0;
  logic [SW-1:0] stateIn = '0;
  logic [EW-1:0] errPulse, errSticky;

  int total = 0;
  int bad = 0;
  expItem_t sbQ[$];

  logic          mPrevValid = 1'b0;
  logic [1:0]    mPrev = 2'b00;
  logic [EW-1:0] mSticky = '0;

  fsm_walk_monitor #(.STATE_W(SW)) dut (
    .clk(clk), .rstN(rstN), .onehotMode(onehotMode),
    .stateValid(stateValid), .stateIn(stateIn),
    .errPulse(errPulse), .errSticky(errSticky)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // drive one sample and push the expected outputs for the next cycle
  task automatic step(input logic v, input logic [SW-1:0] s, input string tag);
    logic [EW-1:0] e;
    logic [1:0] c;
    int ones;
    @(negedge clk);
    stateValid = v;
    stateIn = s;
    e = '0;
    c = s[1:0];
    if (v) begin
      if (onehotMode) begin
        ones = $countones(s);
        if (ones != 1) e[4] = 1'b1;
      end else begin
        if (c == 2'b11) e[0] = 1'b1;
        if (mPrevValid) begin
          case (mPrev)
            2'b00: if (!(c == 2'b00 || c == 2'b01)) e[1] = 1'b1;
            2'b01: if (!(c == 2'b01 || c == 2'b10)) e[2] = 1'b1;
            2'b10: if (c != 2'b00) e[3] = 1'b1;
            default: ;
          endcase
        end
      end
      mPrev = c;
    end
    mPrevValid = v;
    mSticky = mSticky | e;
    sbQ.push_back('{pulse: e, sticky: mSticky, tag: tag});
  endtask

  task automatic doReset(input logic v, input logic [SW-1:0] s);
    @(negedge clk);
    rstN = 1'b0;
    stateValid = v;
    stateIn = s;
    repeat (2) @(negedge clk);
    total++;
    if (errPulse !== '0 || errSticky !== '0) begin
      bad++;
      $display("FAIL R8 reset: pulse=%b sticky=%b expected 00000/00000",
               errPulse, errSticky);
    end
    rstN = 1'b1;
    stateValid = 1'b0;
    mPrevValid = 1'b0;
    mSticky = '0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        total++;
        if (errPulse !== it.pulse || errSticky !== it.sticky) begin
          bad++;
          $display("FAIL %s: pulse=%b sticky=%b expected pulse=%b sticky=%b",
                   it.tag, errPulse, errSticky, it.pulse, it.sticky);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (errPulse !== '0 || errSticky !== '0) begin
      bad++;
      $display("FAIL R8 initial reset: pulse=%b sticky=%b expected 0/0", errPulse, errSticky);
    end
    rstN = 1'b1;

    // legal walk with wait states
    step(1, 5'b00000, "R5 first sample");
    step(1, 5'b00000, "R2 idle wait");
    step(1, 5'b00001, "R2 idle to run");
    step(1, 5'b00001, "R3 run wait");
    step(1, 5'b00010, "R3 run to done");
    step(1, 5'b00000, "R4 done to idle");
    // illegal jumps from each source
    step(1, 5'b00010, "R2 idle to done");
    step(1, 5'b00001, "R4 done to run");
    step(1, 5'b00000, "R3 run to idle");
    // invalid encoding
    step(1, 5'b00011, "R1 R2 idle to bad");
    step(1, 5'b00000, "R4 bad source quiet");
    step(1, 5'b10100, "R1 upper bits ignored");
    step(1, 5'b01101, "R1 upper bits run");
    step(1, 5'b00011, "R3 run to bad");
    // gap handling
    step(1, 5'b00000, "R5 idle before gap");
    step(0, 5'b00011, "R5 invalid cycle quiet");
    step(1, 5'b00010, "R5 fresh after gap");
    step(1, 5'b00001, "R4 done to run after gap");
    // reset with bad inputs, then fresh start
    doReset(1, 5'b00011);
    step(1, 5'b00010, "R8 R5 first after reset");
    step(1, 5'b00000, "R7 done to idle clean");
    step(1, 5'b00000, "R7 sticky stays clear");
    step(1, 5'b00001, "R2 idle to run");
    step(1, 5'b00001, "R3 run wait");
    step(0, 5'b00000, "R7 pulse drops");

    // onehot mode
    doReset(0, 5'b00000);
    onehotMode = 1'b1;
    step(1, 5'b00001, "R6 single bit");
    step(1, 5'b00000, "R6 all zero");
    step(1, 5'b10000, "R6 top bit");
    step(1, 5'b00110, "R6 two bits");
    step(1, 5'b00011, "R6 no encoded flag");
    step(1, 5'b11111, "R6 all bits");
    step(1, 5'b00100, "R6 jump not judged");
    step(0, 5'b00000, "R6 invalid quiet");
    step(1, 5'b01000, "R6 single bit again");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule